// File: doc/BRIEF.md
# Dual-Byte 8b/10b Transmit Encoder

This block turns a 16-bit transmit word into a 20-bit line word once per clock. Each of the two bytes is mapped to a 10-bit code group by its own 8b/10b encoder. The running disparity is handed from the low group to the high group, and from the high group to the low group of the next word. The 20-bit word feeds a serializer that sends bit 0 first, so the low byte goes out first.

Two control inputs pick what is sent. With the enable input high and the error input low, the data bytes are sent. The other three combinations replace the data with fixed pairs of control groups: an idle set, a carrier-extend pair or an error-propagation pair. The idle set is a comma-bearing K28.5 followed by a data group. That data group is chosen so that the running disparity is negative at the end of every idle word, which gives the link a known disparity after idle.

Top module: `dual_byte_8b10b_enc`

## Requirements
- R1: The output is registered. A word presented at a rising edge appears on `code_word` after that edge. While `rst_n` is low, `code_word` is all zeros.
- R2: With `tx_en`=1 and `tx_er`=0, `tx_data[7:0]` is encoded as a data group in `code_word[9:0]` and `tx_data[15:8]` in `code_word[19:10]`. Within each group, bit 0 carries code bit a and bit 9 carries code bit j (order abcdei fghj).
- R3: The running disparity starts negative after reset. The low group of a word is encoded with the disparity left by the previous word's high group. The high group is encoded with the disparity left by the low group.
- R4: With `tx_en`=0 and `tx_er`=0, the low group is K28.5 (0xBC). The high group is D16.2 (0x50) if the disparity after K28.5 is positive, or D5.6 (0xC5) if it is negative. The disparity is negative after every idle word. At negative disparity, `code_word[6:0]` holds the comma 0011111 (a first).
- R5: With `tx_en`=0 and `tx_er`=1, both groups are K23.7 (0xF7), and `tx_data` has no effect.
- R6: With `tx_en`=1 and `tx_er`=1, both groups are K30.7 (0xFE), and `tx_data` has no effect.
- R7: For D.x.7, the alternate 4-bit form is used when x is 17, 18 or 20 at negative disparity, or when x is 11, 13 or 14 at positive disparity. All other D.x.7 groups use the primary form.
- R8: Every code group holds four, five or six ones. A six-ones group appears only at negative disparity, and a four-ones group only at positive disparity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Data enable control |
| tx_er | input | 1 | Error control |
| tx_data | input | 16 | Two bytes to send; the low byte goes first |
| code_word | output | 20 | Two registered 10-bit code groups; bit 0 is sent first |

## Verification
The assertions assume that `tx_en` and `tx_er` are stable across each rising edge, so the mode of the previous cycle identifies the word on the output. They also track disparity only from the weights of the output groups, so they trust that a reset arrives before any word they judge. The bench changes inputs only at falling edges and asserts reset before the first word. It drives the control modes at both signs of disparity, with unrelated data on the data bus in the control modes, to reach both idle forms and both forms of each control group.

// File: rtl/dual_byte_8b10b_enc.sv
module dual_byte_8b10b_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        tx_er,
  input  logic [15:0] tx_data,
  output logic [19:0] code_word
);

  localparam logic [7:0] BYTE_K28_5 = 8'hBC;
  localparam logic [7:0] BYTE_K23_7 = 8'hF7;
  localparam logic [7:0] BYTE_K30_7 = 8'hFE;
  localparam logic [7:0] BYTE_D5_6  = 8'hC5;
  localparam logic [7:0] BYTE_D16_2 = 8'h50;

  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;
      5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;
      5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;
      5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;
      5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;
      5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;
      5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;
      5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;
      5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;
      5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;
      5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;
      5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;
      5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;
      5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;
      5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;
      5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;
      default: six_neg = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;
      3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;
      3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;
      3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;
      default: four_neg = 4'b1110;
    endcase
  endfunction

  // returns {disparity_out, group}; group bit 0 is code bit a
  function automatic logic [10:0] enc_group(input logic [7:0] b, input logic k, input logic rd_in);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s6, c6;
    logic [3:0] s4, c4;
    logic       bal6, bal4, rd_mid, rd_out, alt;
    logic [9:0] lit, grp;
    x = b[4:0];
    y = b[7:5];
    s6 = (k && x == 5'd28) ? 6'b001111 : six_neg(x);
    bal6 = ($countones(s6) == 3);
    c6 = (rd_in && (!bal6 || (!k && x == 5'd7))) ? ~s6 : s6;
    rd_mid = bal6 ? rd_in : ~rd_in;
    alt = (y == 3'd7) && (k || (rd_mid ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                                       : (x == 5'd17 || x == 5'd18 || x == 5'd20)));
    s4 = alt ? 4'b0111 : four_neg(y);
    bal4 = ($countones(s4) == 2);
    if (k && x == 5'd28 && bal4 && y != 3'd3)
      c4 = rd_in ? ~s4 : s4;
    else
      c4 = (rd_mid && (!bal4 || y == 3'd3)) ? ~s4 : s4;
    rd_out = bal4 ? rd_mid : ~rd_mid;
    lit = {c6, c4};
    for (int i = 0; i < 10; i++) grp[i] = lit[9-i];
    return {rd_out, grp};
  endfunction

  logic        rd_q;
  logic [7:0]  lo_byte, hi_byte;
  logic        lo_k, hi_k, idle;
  logic [10:0] lo_enc, hi_enc;

  assign idle = !tx_en && !tx_er;

  always_comb begin
    lo_k    = 1'b1;
    hi_k    = 1'b1;
    lo_byte = BYTE_K28_5;
    hi_byte = BYTE_K28_5;
    case ({tx_en, tx_er})
      2'b10: begin
        lo_byte = tx_data[7:0];
        hi_byte = tx_data[15:8];
        lo_k    = 1'b0;
        hi_k    = 1'b0;
      end
      2'b01: begin
        lo_byte = BYTE_K23_7;
        hi_byte = BYTE_K23_7;
      end
      2'b11: begin
        lo_byte = BYTE_K30_7;
        hi_byte = BYTE_K30_7;
      end
      default: ;
    endcase
    lo_enc = enc_group(lo_byte, lo_k, rd_q);
    if (idle) begin
      hi_byte = lo_enc[10] ? BYTE_D16_2 : BYTE_D5_6;
      hi_k    = 1'b0;
    end
    hi_enc = enc_group(hi_byte, hi_k, lo_enc[10]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      code_word <= '0;
    end else begin
      rd_q      <= hi_enc[10];
      code_word <= {hi_enc[9:0], lo_enc[9:0]};
    end
  end

endmodule

module dual_byte_8b10b_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_en,
  input logic        tx_er,
  input logic [19:0] code_word
);

  function automatic logic [9:0] flip10(input logic [9:0] v);
    for (int i = 0; i < 10; i++) flip10[i] = v[9-i];
  endfunction

  localparam logic [9:0] K285_N = 10'b0011111010;
  localparam logic [9:0] K285_P = 10'b1100000101;
  localparam logic [9:0] K237_N = 10'b1110101000;
  localparam logic [9:0] K237_P = 10'b0001010111;
  localparam logic [9:0] K307_N = 10'b0111101000;
  localparam logic [9:0] K307_P = 10'b1000010111;

  logic [9:0] lo, hi;
  int         w_lo, w_hi;
  logic       vld, rd_c, rd_mid_c, rd_end_c;

  assign lo = code_word[9:0];
  assign hi = code_word[19:10];

  always_comb begin
    w_lo = $countones(lo);
    w_hi = $countones(hi);
    rd_mid_c = (w_lo == 6) ? 1'b1 : (w_lo == 4) ? 1'b0 : rd_c;
    rd_end_c = (w_hi == 6) ? 1'b1 : (w_hi == 4) ? 1'b0 : rd_mid_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      rd_c <= 1'b0;
    end else begin
      vld <= 1'b1;
      if (vld) rd_c <= rd_end_c;
    end
  end

  a_r8_group_weight: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (w_lo >= 4 && w_lo <= 6 && w_hi >= 4 && w_hi <= 6));

  a_r3_disparity_chain: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> !((w_lo == 6 && rd_c) || (w_lo == 4 && !rd_c) ||
              (w_hi == 6 && rd_mid_c) || (w_hi == 4 && !rd_mid_c)));

  a_r4_idle_set: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(!tx_en && !tx_er)) |->
      ((lo == flip10(K285_N) || lo == flip10(K285_P)) && !rd_end_c));

  a_r5_carrier_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(!tx_en && tx_er)) |->
      ((lo == flip10(K237_N) || lo == flip10(K237_P)) &&
       (hi == flip10(K237_N) || hi == flip10(K237_P))));

  a_r6_error_prop: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(tx_en && tx_er)) |->
      ((lo == flip10(K307_N) || lo == flip10(K307_P)) &&
       (hi == flip10(K307_N) || hi == flip10(K307_P))));

endmodule

bind dual_byte_8b10b_enc dual_byte_8b10b_enc_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .tx_er     (tx_er),
  .code_word (code_word)
);

// File: tb/dual_byte_8b10b_enc_tb_top.sv
module dual_byte_8b10b_enc_tb_top;

  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        tx_er = 1'b0;
  logic [15:0] tx_data = '0;
  logic [19:0] code_word;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_byte_8b10b_enc dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .tx_data(tx_data), .code_word(code_word)
  );

  // groups written abcdei fghj
  localparam logic [9:0] K285_N = 10'b0011111010;
  localparam logic [9:0] K285_P = 10'b1100000101;
  localparam logic [9:0] D162_P = 10'b1001000101;
  localparam logic [9:0] D56    = 10'b1010010110;
  localparam logic [9:0] D00_N  = 10'b1001110100;
  localparam logic [9:0] D00_P  = 10'b0110001011;
  localparam logic [9:0] D01_N  = 10'b1001111001;
  localparam logic [9:0] D01_P  = 10'b0110001001;
  localparam logic [9:0] K237_N = 10'b1110101000;
  localparam logic [9:0] K237_P = 10'b0001010111;
  localparam logic [9:0] K307_N = 10'b0111101000;
  localparam logic [9:0] K307_P = 10'b1000010111;
  localparam logic [9:0] D177_N = 10'b1000110111;
  localparam logic [9:0] D177_P = 10'b1000110001;
  localparam logic [9:0] D117_P = 10'b1101001000;
  localparam logic [9:0] D215   = 10'b1010101010;

  function automatic logic [19:0] pk(input logic [9:0] hi, input logic [9:0] lo);
    for (int i = 0; i < 10; i++) begin
      pk[i]    = lo[9-i];
      pk[10+i] = hi[9-i];
    end
  endfunction

  task automatic check(input logic [19:0] act, input logic [19:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic send(input logic en, input logic er, input logic [15:0] d,
                      input logic [19:0] exp, input string req);
    tx_en = en; tx_er = er; tx_data = d;
    @(negedge clk);
    check(code_word, exp, req);
  endtask

  task automatic t_reset_state;
    #1 check(code_word, 20'h0, "R1 reset value");
    repeat (3) @(negedge clk);
    check(code_word, 20'h0, "R1 held in reset");
    rst_n = 1'b1;
  endtask

  task automatic t_idle_negative;
    send(1'b0, 1'b0, 16'hFFFF, pk(D162_P, K285_N), "R4 idle from negative");
    check({13'h0, code_word[6:0]}, {13'h0, 7'b1111100}, "R4 comma bits");
  endtask

  task automatic t_data_words;
    send(1'b1, 1'b0, 16'h0000, pk(D00_N, D00_N), "R2 D0.0 pair");
    send(1'b1, 1'b0, 16'h0020, pk(D00_P, D01_N), "R3 disparity handed low to high");
  endtask

  task automatic t_idle_positive;
    send(1'b0, 1'b0, 16'h1357, pk(D56, K285_P), "R4 idle from positive");
  endtask

  task automatic t_control_negative;
    send(1'b0, 1'b1, 16'h1234, pk(K237_N, K237_N), "R5 carrier extend negative");
    send(1'b1, 1'b1, 16'hABCD, pk(K307_N, K307_N), "R6 error propagation negative");
  endtask

  task automatic t_control_positive;
    send(1'b1, 1'b0, 16'h2020, pk(D01_P, D01_N), "R3 flip and flip back");
    send(1'b1, 1'b0, 16'h0020, pk(D00_P, D01_N), "R3 end positive");
    send(1'b0, 1'b1, 16'h5A5A, pk(K237_P, K237_P), "R5 carrier extend positive");
    send(1'b1, 1'b1, 16'h0F0F, pk(K307_P, K307_P), "R6 error propagation positive");
    send(1'b0, 1'b0, 16'h0000, pk(D56, K285_P), "R4 idle restores negative");
  endtask

  task automatic t_alt7;
    send(1'b1, 1'b0, 16'hEBF1, pk(D117_P, D177_N), "R7 alternate forms both signs");
    send(1'b1, 1'b0, 16'hF1F1, pk(D177_P, D177_N), "R7 primary at positive");
    send(1'b1, 1'b0, 16'hB5B5, pk(D215, D215), "R2 neutral D21.5");
  endtask

  task automatic t_reset_midstream;
    send(1'b1, 1'b0, 16'h0020, pk(D00_P, D01_N), "R3 positive before reset");
    rst_n = 1'b0;
    #1 check(code_word, 20'h0, "R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b0, 1'b0, 16'h0000, pk(D162_P, K285_N), "R3 disparity negative after reset");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state;
    t_idle_negative;
    t_data_words;
    t_idle_positive;
    t_control_negative;
    t_control_positive;
    t_alt7;
    t_reset_midstream;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule